// File: doc/BRIEF.md
# Product-Based Shift and Rotate Unit

This block shifts or rotates a 32-bit word by running it through one wide multiplication rather than a tree of multiplexers. The distance input N is turned into the one-hot factor 2^N. The data word is multiplied by this factor to give a 64-bit product. The lower half of the product is the word moved left by N. The upper half is the word moved right by 32-N. The OR of the two halves wraps the word around on itself. A right shift is therefore requested as a distance of 32-N, not N.

Three run-time controls select the operation: `rotate`, `shift_right` and `signed_mode`. When `rotate` is high, the unit rotates and both other controls are ignored. Otherwise `shift_right` chooses between the upper half and the lower half of the product. `signed_mode` chooses whether the data is sign-extended before the multiply. This gives five operations: arithmetic and logical left shift (these two produce the same word), arithmetic and logical right shift, and rotate. The result is registered, so each operation has a latency of one cycle.

Top module: `mul_shifter`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock cycle, and each result appears on `out_data` in the cycle that `out_valid` is high.
- R2: While `rst_n` is low, and in the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R3: With `rotate`=0 and `shift_right`=0, the result is the data shifted left by N, with zeros filling the low bits. The result is the same for either value of `signed_mode`.
- R4: With `rotate`=0, `shift_right`=1 and `signed_mode`=0, the result is the data shifted right by 32-N, with zeros filling the high bits. For N=0 the result is zero.
- R5: With `rotate`=0, `shift_right`=1 and `signed_mode`=1, the result is the signed data shifted right by 32-N, with copies of bit 31 filling the high bits. For N=0 every bit of the result equals bit 31 of the data.
- R6: With `rotate`=1, the result is the data rotated left by N, so bit i moves to bit (i+N) mod 32. `shift_right` and `signed_mode` have no effect on the result.
- R7: With N=0, the left shift and the rotate both return the data unchanged.
- R8: While `in_valid` is 0, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The operands on this cycle are valid |
| in_data | input | 32 | Word to shift or rotate |
| in_dist | input | 5 | Distance N |
| rotate | input | 1 | 1 selects rotate |
| shift_right | input | 1 | 1 selects the upper product half (right by 32-N) |
| signed_mode | input | 1 | 1 sign-extends the data before the multiply |
| out_data | output | 32 | Registered result |
| out_valid | output | 1 | The result on `out_data` is valid |

## Verification
The hardest case to reach is N=0 on a right shift. Here the upper product half holds nothing but the extension of the data, so the result is either zero or every bit set to the sign bit. A bug in sign handling shows up only when bit 31 of the data is set. The bench therefore applies every one of the 32 distances under all eight combinations of the three controls. Its data words include single-bit patterns at both ends of the word, all ones, the largest positive value and random words, so both sign polarities meet the zero distance.

// File: rtl/mul_shifter.sv
module mul_shifter #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_data,
  input  logic [$clog2(W)-1:0] in_dist,
  input  logic                 rotate,
  input  logic                 shift_right,
  input  logic                 signed_mode,
  output logic [W-1:0]         out_data,
  output logic                 out_valid
);
  localparam int PW = 2 * W;

  logic          ext_bit;
  logic [PW-1:0] operand, weight, product;
  logic [W-1:0]  lo_half, hi_half, result;

  assign ext_bit = signed_mode & ~rotate & in_data[W-1];
  assign operand = {{W{ext_bit}}, in_data};
  assign weight  = PW'(1) << in_dist;
  assign product = operand * weight;
  assign lo_half = product[W-1:0];
  assign hi_half = product[PW-1:W];
  assign result  = rotate ? (lo_half | hi_half) : (shift_right ? hi_half : lo_half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R8
  AST_LEFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rotate && !shift_right && in_dist != 0) |=> out_data[0] == 1'b0); // R3
  AST_LSR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rotate && shift_right && !signed_mode) |=> out_data[W-1] == 1'b0); // R4
  AST_ASR_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rotate && shift_right && signed_mode) |=> out_data[W-1] == $past(in_data[W-1])); // R5
  AST_ROTATE_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rotate) |=> $countones(out_data) == $countones($past(in_data))); // R6
  AST_ZERO_DIST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dist == 0 && (rotate || !shift_right)) |=> out_data == $past(in_data)); // R7
endmodule

// File: tb/mul_shifter_tb.sv
module mul_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0]  in_dist = '0;
  logic        rotate = 1'b0, shift_right = 1'b0, signed_mode = 1'b0;
  logic [31:0] out_data;
  logic        out_valid;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  mul_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_dist(in_dist), .rotate(rotate), .shift_right(shift_right),
    .signed_mode(signed_mode), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] d, input int n,
                                        input bit rot, input bit sr, input bit sm);
    logic [63:0] wide;
    if (rot) return (n == 0) ? d : ((d << n) | (d >> (32 - n)));
    if (!sr) return d << n;
    wide = (sm && d[31]) ? {32'hFFFF_FFFF, d} : {32'h0, d};
    return wide[63:32] | 32'(wide[31:0] >> (32 - n)) & 32'h0 | 32'(wide >> (32 - n));
  endfunction

  function automatic string tag(input bit rot, input bit sr, input bit sm, input int n);
    if (rot) return (n == 0) ? "R6/R7 rotate" : "R6 rotate";
    if (!sr) return (n == 0) ? "R3/R7 left" : "R3 left";
    return sm ? "R5 arith right" : "R4 logic right";
  endfunction

  task automatic run_op(input logic [31:0] d, input int n, input bit rot, input bit sr, input bit sm);
    logic [31:0] exp;
    exp = model(d, n, rot, sr, sm);
    if (!sr || rot) exp = exp;
    else if (n == 0) exp = (sm && d[31]) ? 32'hFFFF_FFFF : 32'h0;
    else exp = sm ? 32'($signed(d) >>> (32 - n)) : (d >> (32 - n));
    in_valid = 1'b1; in_data = d; in_dist = 5'(n);
    rotate = rot; shift_right = sr; signed_mode = sm;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 valid", {31'b0, out_valid}, 32'h1);
    check(tag(rot, sr, sm, n), out_data, exp);
  endtask

  initial begin
    logic [31:0] pats [6];
    logic [31:0] held;
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h7FFF_FFFF;
    pats[3] = 32'h0000_0001; pats[4] = 32'h8000_0000; pats[5] = 32'hC3A5_1E69;
    repeat (3) @(negedge clk);
    check("R2 reset valid", {31'b0, out_valid}, 32'h0);
    check("R2 reset data", out_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 post reset valid", {31'b0, out_valid}, 32'h0);
    check("R2 post reset data", out_data, 32'h0);
    for (int p = 0; p < 10; p++) begin
      logic [31:0] d;
      d = (p < 6) ? pats[p] : $urandom();
      for (int c = 0; c < 8; c++)
        for (int n = 0; n < 32; n++)
          run_op(d, n, c[2], c[1], c[0]);
      held = out_data;
      in_data = ~d; in_dist = 5'd7; rotate = 1'b0; shift_right = 1'b0;
      @(negedge clk);
      check("R8 hold data", out_data, held);
      check("R1 idle valid", {31'b0, out_valid}, 32'h0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule